// File: doc/BRIEF.md
# Cartridge Bank Register File

This block holds the banking state of a game-cartridge memory mapper. It watches CPU write cycles, which carry a 16-bit address and an 8-bit data byte and are qualified by a write strobe. From these writes it keeps three program-ROM slot numbers of 8 KB each, eight character-ROM bank numbers of 1 KB each, and a nametable mirroring mode.

Two lookups are combinational. A CPU address in the 0x8000 to 0xFFFF window is turned into an 8 KB program bank index. A 13-bit PPU pattern address is turned into a 1 KB character bank number. The mirroring select drives the nametable logic outside the block.

The size of the program ROM, counted in 8 KB banks, is a parameter (`PRG_BANKS`). A write to one control address with one chosen value returns all program and character banking to its start-up layout.

Top module: `cart_bank_regs`

## Requirements
- R1: After reset, the four program slots at 0x8000, 0xA000, 0xC000 and 0xE000 (selected by `cpu_addr[14:13]` = 0..3) map to banks 0, 1, PRG_BANKS-2 and PRG_BANKS-1.
- R2: The slot at 0xE000 always maps to bank PRG_BANKS-1, whatever has been written.
- R3: After reset, character slot n (selected by `ppu_addr[12:10]` = n) maps to bank n, for n from 0 to 7.
- R4: Program bank writes decode exactly. A write to 0x8800 loads the 0x8000 slot, 0xA800 loads the 0xA000 slot, and 0xA000 loads the 0xC000 slot, each with the full data byte.
- R5: Character bank n has a low-nibble address L(n). L(0..7) are 0xB000, 0xB008, 0xC000, 0xC008, 0xD000, 0xD008, 0xE000 and 0xE008, and the high-nibble address is L(n)+4. A write to L(n) replaces bits 3:0 of bank n with data bits 3:0. A write to L(n)+4 replaces bits 7:4 of bank n with data bits 3:0. The other nibble keeps its value.
- R6: Writing 0x01 to 0x9008 restores the R1 program layout and the R3 character layout. Any other value written there changes nothing.
- R7: The mirroring mode powers up as 0. A write to 0x9800 with a value from 0 to 3 sets it (0 vertical, 1 horizontal, 2 single-screen low, 3 single-screen high). Larger values leave it unchanged.
- R8: A write to any other address, and any cycle with `wr_en` low, changes no banking or mirroring state.
- R9: The program bank driven out is the stored 8-bit value modulo PRG_BANKS.
- R10: The soft restore of R6 leaves the mirroring mode unchanged.
- R11: A write takes effect at the clock edge that samples it. The lookup outputs show the old value in the write cycle and the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 16 | CPU address to translate |
| ppu_addr | input | 13 | PPU pattern address to translate |
| prg_bank | output | $clog2(PRG_BANKS) | 8 KB program bank for `cpu_addr` |
| chr_bank | output | 8 | 1 KB character bank for `ppu_addr` |
| mirror_mode | output | 2 | Nametable mirroring select |

## Verification
The write path and the lookup path can land on the same register in the same cycle. A bank write and a combinational translation of that same slot then coincide. The bench holds a write to a character slot on the bus while pointing `ppu_addr` at that slot. It samples before the edge, where the old number is expected, and just after the edge, where the new number is expected. Random writes, with addresses drawn from the decoded set and from near misses, are scored the same way against a bench model after every batch.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int PRG_WR_SLOTS = 3;
  localparam int CHR_SLOTS    = 8;
  localparam int BANK_W       = 8;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_L = 2'd2,
    MIR_ONE_H = 2'd3
  } mirror_e;

  typedef struct packed {
    logic [PRG_WR_SLOTS-1:0] prg_we;
    logic [CHR_SLOTS-1:0]    chr_we;
    logic                    chr_hi;
    logic                    soft_rst;
    logic                    mir_we;
  } cart_wr_t;
endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
  import cart_bank_pkg::*;
(
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output cart_wr_t    strb
);
  logic [3:0] pair;
  logic       chr_hit;

  always_comb begin
    pair    = wr_addr[15:12] - 4'hB;
    chr_hit = (wr_addr[15:12] >= 4'hB) && (wr_addr[15:12] <= 4'hE) &&
              (wr_addr[11:4] == 8'h00) && (wr_addr[1:0] == 2'b00);
  end

  always_comb begin
    strb = '0;
    if (wr_en) begin
      unique case (wr_addr)
        16'h8800: strb.prg_we[0] = 1'b1;
        16'hA800: strb.prg_we[1] = 1'b1;
        16'hA000: strb.prg_we[2] = 1'b1;
        16'h9008: strb.soft_rst  = (wr_data == 8'h01);
        16'h9800: strb.mir_we    = (wr_data < 8'd4);
        default: begin
          if (chr_hit) begin
            strb.chr_we[{pair[1:0], wr_addr[3]}] = 1'b1;
            strb.chr_hi = wr_addr[2];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map
  import cart_bank_pkg::*;
#(
  parameter int PRG_BANKS = 12,
  localparam int PRG_AW = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PRG_WR_SLOTS-1:0] prg_we,
  input  logic                    soft_rst,
  input  logic [BANK_W-1:0]       wr_data,
  input  logic [1:0]              slot_sel,
  output logic [PRG_AW-1:0]       prg_bank
);
  localparam logic [BANK_W:0]   NB     = (BANK_W+1)'(PRG_BANKS);
  localparam logic [BANK_W-1:0] LAST   = BANK_W'(PRG_BANKS - 1);
  localparam logic [BANK_W-1:0] LAST_M = BANK_W'(PRG_BANKS - 2);

  logic [BANK_W-1:0] slot_q [PRG_WR_SLOTS];
  logic [BANK_W-1:0] slot_d [PRG_WR_SLOTS];
  logic [BANK_W-1:0] rst_val [PRG_WR_SLOTS];
  logic [BANK_W-1:0] sel;
  logic [BANK_W:0]   reduced;

  always_comb begin
    rst_val[0] = 8'd0;
    rst_val[1] = 8'd1;
    rst_val[2] = LAST_M;
  end

  generate
    for (genvar i = 0; i < PRG_WR_SLOTS; i++) begin : g_slot
      always_comb begin
        slot_d[i] = slot_q[i];
        if (soft_rst)       slot_d[i] = rst_val[i];
        else if (prg_we[i]) slot_d[i] = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       slot_q[i] <= rst_val[i];
        else if (soft_rst || prg_we[i])   slot_q[i] <= slot_d[i];
      end

      p_prg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_we[i] && !soft_rst) |=> (slot_q[i] == $past(wr_data)));
    end
  endgenerate

  always_comb begin
    sel      = (slot_sel == 2'd3) ? LAST : slot_q[slot_sel];
    reduced  = {1'b0, sel} % NB;
    prg_bank = reduced[PRG_AW-1:0];
  end

  p_prg_softrst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (slot_q[0] == 8'd0 && slot_q[1] == 8'd1 && slot_q[2] == LAST_M));
endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map
  import cart_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CHR_SLOTS-1:0] chr_we,
  input  logic                 chr_hi,
  input  logic                 soft_rst,
  input  logic [3:0]           nib,
  input  logic [2:0]           slot_sel,
  output logic [BANK_W-1:0]    chr_bank
);
  logic [BANK_W-1:0] bank_q [CHR_SLOTS];
  logic [BANK_W-1:0] bank_d [CHR_SLOTS];

  generate
    for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_bank
      always_comb begin
        bank_d[i] = bank_q[i];
        if (soft_rst)           bank_d[i] = BANK_W'(i);
        else if (chr_we[i]) begin
          if (chr_hi)           bank_d[i][7:4] = nib;
          else                  bank_d[i][3:0] = nib;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      bank_q[i] <= BANK_W'(i);
        else if (soft_rst || chr_we[i])  bank_q[i] <= bank_d[i];
      end

      p_chr_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_we[i] && !chr_hi && !soft_rst) |=>
          (bank_q[i][3:0] == $past(nib)) && $stable(bank_q[i][7:4]));
      p_chr_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_we[i] && chr_hi && !soft_rst) |=>
          (bank_q[i][7:4] == $past(nib)) && $stable(bank_q[i][3:0]));
      p_chr_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (bank_q[i] == BANK_W'(i)));
    end
  endgenerate

  assign chr_bank = bank_q[slot_sel];
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int PRG_BANKS = 12,
  localparam int PRG_AW = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [15:0]       cpu_addr,
  input  logic [12:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_bank,
  output logic [7:0]        chr_bank,
  output logic [1:0]        mirror_mode
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  cart_wr_t   strb;
  mirror_e    mir_q, mir_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cart_wr_decode u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .strb    (strb)
  );

  cart_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .prg_we   (strb.prg_we),
    .soft_rst (strb.soft_rst),
    .wr_data  (wr_data),
    .slot_sel (cpu_addr[14:13]),
    .prg_bank (prg_bank)
  );

  cart_chr_map u_chr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .chr_we   (strb.chr_we),
    .chr_hi   (strb.chr_hi),
    .soft_rst (strb.soft_rst),
    .nib      (wr_data[3:0]),
    .slot_sel (ppu_addr[12:10]),
    .chr_bank (chr_bank)
  );

  always_comb mir_d = strb.mir_we ? mirror_e'(wr_data[1:0]) : mir_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)      mir_q <= MIR_VERT;
    else if (strb.mir_we) mir_q <= mir_d;
  end
  assign mirror_mode = mir_q;

  p_mirror_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && wr_addr == 16'h9800 && wr_data < 8'd4) |=> $stable(mirror_mode));
  p_mirror_keep_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == 16'h9008) |=> $stable(mirror_mode));
  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({strb.prg_we, strb.chr_we, strb.soft_rst, strb.mir_we}));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |-> (strb == '0));
  p_last_slot_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_addr[14:13] == 2'd3) |-> (prg_bank == PRG_AW'(PRG_BANKS - 1)));
  p_prg_range_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (32'(prg_bank) < PRG_BANKS));
endmodule

// File: tb/cart_bank_regs_tb.sv
`timescale 1ns/1ps
module cart_bank_regs_tb;
  localparam int NB = 12;
  localparam int AW = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] cpu_addr;
  logic [12:0] ppu_addr;
  logic [AW-1:0] prg_bank;
  logic [7:0] chr_bank;
  logic [1:0] mirror_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_prg [3];
  logic [7:0] m_chr [8];
  logic [1:0] m_mir;

  always #4 clk = ~clk;

  cart_bank_regs #(.PRG_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror_mode(mirror_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_restore();
    m_prg[0] = 8'd0; m_prg[1] = 8'd1; m_prg[2] = 8'(NB - 2);
    for (int i = 0; i < 8; i++) m_chr[i] = 8'(i);
  endtask

  function automatic int exp_prg(input int slot);
    if (slot == 3) return NB - 1;
    return int'(m_prg[slot]) % NB;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    int idx;
    case (a)
      16'h8800: m_prg[0] = d;
      16'hA800: m_prg[1] = d;
      16'hA000: m_prg[2] = d;
      16'h9008: if (d == 8'h01) model_restore();
      16'h9800: if (d < 8'd4) m_mir = d[1:0];
      default: begin
        for (int n = 0; n < 8; n++) begin
          idx = 16'hB000 + (n / 2) * 16'h1000 + (n % 2) * 8;
          if (a == 16'(idx))     m_chr[n][3:0] = d[3:0];
          if (a == 16'(idx + 4)) m_chr[n][7:4] = d[3:0];
        end
      end
    endcase
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input bit en);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en) model_write(a, d);
  endtask

  task automatic check_all(input string req);
    for (int s = 0; s < 4; s++) begin
      cpu_addr = 16'h8000 | 16'(s << 13) | 16'($urandom % 8192);
      #1;
      check(int'(prg_bank) == exp_prg(s), req, int'(prg_bank), exp_prg(s));
    end
    for (int c = 0; c < 8; c++) begin
      ppu_addr = 13'(c << 10) | 13'($urandom % 1024);
      #1;
      check(chr_bank == m_chr[c], req, int'(chr_bank), int'(m_chr[c]));
    end
    check(mirror_mode == m_mir, req, int'(mirror_mode), int'(m_mir));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  logic [15:0] pool [20];

  initial begin
    void'($urandom(32'h5EED_0183));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cpu_addr = 16'h8000; ppu_addr = '0;
    model_restore(); m_mir = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check_all("R1 R3 R7 reset state");

    // R4 / R9 program slot loads, including values beyond the ROM size
    do_write(16'h8800, 8'h05, 1'b1);
    do_write(16'hA800, 8'h0B, 1'b1);
    do_write(16'hA000, 8'hFF, 1'b1);
    check_all("R4 R9 program loads");
    // R2 last slot fixed
    cpu_addr = 16'hE123; #1;
    check(int'(prg_bank) == NB - 1, "R2 fixed last slot", int'(prg_bank), NB - 1);

    // R5 nibble writes on every character bank
    for (int n = 0; n < 8; n++) begin
      do_write(16'(16'hB000 + (n / 2) * 16'h1000 + (n % 2) * 8), 8'hF0 | 8'(n + 8), 1'b1);
      do_write(16'(16'hB004 + (n / 2) * 16'h1000 + (n % 2) * 8), 8'hA0 | 8'(15 - n), 1'b1);
    end
    check_all("R5 nibble writes");

    // R8 near misses and strobe low
    do_write(16'h8801, 8'h33, 1'b1);
    do_write(16'hB001, 8'h0C, 1'b1);
    do_write(16'hB010, 8'h0C, 1'b1);
    do_write(16'hA801, 8'h07, 1'b1);
    do_write(16'h8800, 8'h09, 1'b0);
    do_write(16'hE00C, 8'h01, 1'b0);
    check_all("R8 ignored writes");

    // R7 mirroring values
    do_write(16'h9800, 8'h03, 1'b1);
    check_all("R7 mirror set 3");
    do_write(16'h9800, 8'h07, 1'b1);
    check_all("R7 mirror ignores 7");
    do_write(16'h9800, 8'h01, 1'b1);

    // R6 soft restore: wrong value ignored, 0x01 restores; R10 mirror kept
    do_write(16'h9008, 8'h02, 1'b1);
    check_all("R6 restore ignores 0x02");
    do_write(16'h9008, 8'h01, 1'b1);
    check_all("R6 R10 restore");
    check(mirror_mode == 2'd1, "R10 mirror kept", int'(mirror_mode), 1);

    // R11 same-cycle write and lookup of character slot 2
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'hC000; wr_data = 8'h09;
    ppu_addr = 13'(2 << 10);
    #1;
    check(chr_bank == m_chr[2], "R11 old value in write cycle", int'(chr_bank), int'(m_chr[2]));
    @(posedge clk); #1;
    check(chr_bank == {m_chr[2][7:4], 4'h9}, "R11 new value after edge",
          int'(chr_bank), int'({m_chr[2][7:4], 4'h9}));
    @(negedge clk);
    wr_en = 1'b0;
    model_write(16'hC000, 8'h09);

    // Random mix
    pool[0] = 16'h8800; pool[1] = 16'hA800; pool[2] = 16'hA000; pool[3] = 16'h9008;
    pool[4] = 16'h9800; pool[5] = 16'hB000; pool[6] = 16'hB00C; pool[7] = 16'hC004;
    pool[8] = 16'hC008; pool[9] = 16'hD000; pool[10] = 16'hD00C; pool[11] = 16'hE004;
    pool[12] = 16'hE008; pool[13] = 16'hE00C; pool[14] = 16'h8000; pool[15] = 16'h9000;
    pool[16] = 16'hB002; pool[17] = 16'hF000; pool[18] = 16'hC100; pool[19] = 16'hE010;
    for (int it = 0; it < 3000; it++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = ($urandom % 8 == 0) ? 16'($urandom) : pool[$urandom % 20];
      d = ($urandom % 4 == 0) ? 8'($urandom % 5) : 8'($urandom);
      do_write(a, d, ($urandom % 8) != 0);
      if (it % 20 == 19) check_all("R4 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule